// File: doc/BRIEF.md
# Dual-Unit Conversion Trigger and Channel Sequencer

This block is the digital sequencing front end for two four-input analog-to-digital converter units. The units share one space of eight analog inputs. Unit 0 serves inputs 0 to 3 and unit 1 serves inputs 4 to 7. For each unit the block tells the converter which input to sample, issues a one-cycle start pulse, and steps forward when the converter reports a finished conversion.

Software programs each unit through two byte-wide registers. The first is a gate register that holds a trigger-enable bit. The second is a configuration register that holds the input code, the mode and a run bit. A conversion can be started in three ways: software sets the run bit, the shared external trigger pin falls, or the shared timer pulse arrives. The two hardware triggers only start a unit whose enable bit is set.

Three separate inputs reset the block: power-on, manual reset and standby. Each one clears a different amount of state.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After power-on reset, each gate register reads 0x7F and each configuration register reads 0x00. No start pulse is issued. Each unit's channel output is its base input: 0 for unit 0 and 4 for unit 1.
- R2: In the gate register, only bit 7 (trigger enable) can be written. Bits 6 to 0 always read 1, whatever value was written to them.
- R3: In the configuration register, bit 4 selects the mode (0 = single, 1 = scan) and bits 1:0 hold the input code. In single mode the channel output is the unit base plus the code.
- R4: In scan mode, the channel output steps through base+0 up to base+code, in ascending order. It moves one step after each accepted done pulse, wraps back to base+0, and each step issues a new start pulse.
- R5: While a unit's trigger enable is 0, neither the external pin nor the timer pulse starts that unit.
- R6: With trigger enable set, a falling edge on the external pin starts the unit. The start pulse is high in the third cycle after the clock edge that first sees the pin low. A timer pulse starts the unit in the following cycle.
- R7: The pin and the timer pulse are ORed and fed to both units. Each unit responds only according to its own enable bit.
- R8: Every start pulse lasts exactly one cycle. No start pulse is issued while a unit is idle. A done pulse that arrives in the same cycle as a start pulse is ignored.
- R9: While a unit is running, any trigger or software start is ignored. It does not restart the sequence or change the channel.
- R10: Manual reset stops a running conversion and clears the run bit. The gate register and the mode and code fields keep their values.
- R11: Standby returns the gate register to 0x7F and clears the configuration register.
- R12: Configuration bit 5 is the run bit. In single mode hardware clears it after the done pulse. In scan mode it stays set until software writes it as 0, and that write stops the unit.
- R13: Writing the configuration register with bit 5 set, while the unit is idle, starts the unit at its first input in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| man_rst | input | 1 | Synchronous manual reset |
| standby | input | 1 | Synchronous standby entry |
| ext_trig_n | input | 1 | Shared external trigger pin, asynchronous, acts on its falling edge |
| tmr_trig | input | 1 | Shared timer trigger pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: bit 1 = unit, bit 0 = register (0 gate, 1 configuration) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same coding as wr_addr |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| conv_done | input | 2 | Conversion finished, one bit per unit |
| conv_start | output | 2 | Conversion start pulse, one bit per unit |
| conv_chan | output | 6 | Selected input, 3 bits per unit, unit 0 in the low bits |

## Verification
The results arrive at different delays, and each check waits for the right cycle:
- A register write, a timer pulse or a done pulse is sampled at one clock edge. Its effect on the start pulse, the channel and the read-back shows just after that edge.
- A pin edge passes through two synchroniser flops and an edge flop. Its start pulse therefore appears three edges after the pin goes low.

The bench keeps a behavioural model of each unit that it advances at every rising edge. It compares the model with the outputs and the read data at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    localparam int REG_W        = 8;
    localparam int GATE_EN_BIT  = 7;
    localparam int CFG_RUN_BIT  = 5;
    localparam int CFG_SCAN_BIT = 4;
    localparam logic [REG_W-2:0] GATE_FIXED_ONES = '1;

    typedef enum logic {
        REG_GATE = 1'b0,
        REG_CFG  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n_i,
    input  logic tmr_i,
    output logic trig_o
);
    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     fall;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], pin_n_i};
        st_d.prev = st_q.sync[1];
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign fall   = st_q.prev && !st_q.sync[1];
    assign trig_o = fall || tmr_i;

    assert_fall_from_low_pin_R6: assert property (@(posedge clk) disable iff (!por_n)
        fall |-> !$past(pin_n_i, 2));
endmodule

// File: rtl/adc_unit_seq.sv
module adc_unit_seq
    import adc_scan_pkg::*;
#(
    parameter int CH_PER_UNIT = 4,
    parameter int NCH         = 8,
    parameter int UNIT_IDX    = 0
) (
    input  logic                       clk,
    input  logic                       por_n,
    input  logic                       man_rst_i,
    input  logic                       standby_i,
    input  logic                       trig_i,
    input  logic                       wr_gate_i,
    input  logic                       wr_cfg_i,
    input  logic [REG_W-1:0]           wr_data_i,
    input  logic                       done_i,
    output logic [$clog2(NCH)-1:0]     chan_o,
    output logic                       strobe_o,
    output logic [REG_W-1:0]           gate_rd_o,
    output logic [REG_W-1:0]           cfg_rd_o
);
    localparam int SEL_W = $clog2(CH_PER_UNIT);
    localparam int CH_W  = $clog2(NCH);
    localparam logic [CH_W-1:0] BASE = CH_W'(UNIT_IDX * CH_PER_UNIT);

    typedef struct packed {
        logic             en;
        logic             scan;
        logic [SEL_W-1:0] sel;
        logic             busy;
        logic [SEL_W-1:0] idx;
        logic             strobe;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic     sw_go, sw_stop;

    assign sw_go   = wr_cfg_i &&  wr_data_i[CFG_RUN_BIT];
    assign sw_stop = wr_cfg_i && !wr_data_i[CFG_RUN_BIT];

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (standby_i) begin
            st_d = '0;
        end else if (man_rst_i) begin
            st_d.busy = 1'b0;
            st_d.idx  = '0;
        end else begin
            if (wr_gate_i) st_d.en = wr_data_i[GATE_EN_BIT];
            if (wr_cfg_i) begin
                st_d.scan = wr_data_i[CFG_SCAN_BIT];
                st_d.sel  = wr_data_i[SEL_W-1:0];
            end
            if (st_q.busy) begin
                if (sw_stop) begin
                    st_d.busy = 1'b0;
                    st_d.idx  = '0;
                end else if (done_i && !st_q.strobe) begin
                    if (st_q.scan) begin
                        st_d.idx    = (st_q.idx >= st_q.sel) ? '0 : st_q.idx + 1'b1;
                        st_d.strobe = 1'b1;
                    end else begin
                        st_d.busy = 1'b0;
                    end
                end
            end else if (sw_go || (trig_i && st_q.en)) begin
                st_d.busy   = 1'b1;
                st_d.idx    = '0;
                st_d.strobe = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rd_o               = '0;
        cfg_rd_o[CFG_RUN_BIT]  = st_q.busy;
        cfg_rd_o[CFG_SCAN_BIT] = st_q.scan;
        cfg_rd_o[SEL_W-1:0]    = st_q.sel;
    end

    assign gate_rd_o = {st_q.en, GATE_FIXED_ONES};
    assign strobe_o  = st_q.strobe;
    assign chan_o    = BASE + CH_W'(st_q.scan ? st_q.idx : st_q.sel);

    assert_start_has_cause_R13: assert property (@(posedge clk) disable iff (!por_n)
        $rose(st_q.busy) |-> ($past(wr_cfg_i && wr_data_i[CFG_RUN_BIT]) || $past(trig_i && st_q.en)));

    assert_no_idle_strobe_R8: assert property (@(posedge clk) disable iff (!por_n)
        !st_q.busy |-> !strobe_o);

    assert_strobe_one_cycle_R8: assert property (@(posedge clk) disable iff (!por_n)
        strobe_o |=> !strobe_o);

    assert_busy_ignores_trig_R9: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.busy && trig_i && !done_i && !wr_cfg_i && !man_rst_i && !standby_i)
        |=> (!strobe_o && $stable(chan_o)));

    assert_scan_wrap_R4: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.busy && st_q.scan && done_i && !strobe_o && !wr_cfg_i && !man_rst_i
         && !standby_i && st_q.idx >= st_q.sel) |=> (chan_o == BASE && strobe_o));

    assert_manual_keeps_gate_R10: assert property (@(posedge clk) disable iff (!por_n)
        (man_rst_i && !standby_i) |=> (gate_rd_o == $past(gate_rd_o) && !cfg_rd_o[CFG_RUN_BIT]));

    assert_standby_clears_R11: assert property (@(posedge clk) disable iff (!por_n)
        standby_i |=> (gate_rd_o == {1'b0, GATE_FIXED_ONES} && cfg_rd_o == '0));
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int NUNITS      = 2,
    parameter int CH_PER_UNIT = 4,
    localparam int NCH        = NUNITS * CH_PER_UNIT,
    localparam int CH_W       = $clog2(NCH),
    localparam int UW         = $clog2(NUNITS),
    localparam int AW         = UW + 1
) (
    input  logic                   clk,
    input  logic                   por_n,
    input  logic                   man_rst,
    input  logic                   standby,
    input  logic                   ext_trig_n,
    input  logic                   tmr_trig,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [REG_W-1:0]       wr_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [REG_W-1:0]       rd_data,
    input  logic [NUNITS-1:0]      conv_done,
    output logic [NUNITS-1:0]      conv_start,
    output logic [NUNITS*CH_W-1:0] conv_chan
);
    logic                 trig;
    logic [REG_W-1:0]     gate_rd [NUNITS];
    logic [REG_W-1:0]     cfg_rd  [NUNITS];
    logic [UW-1:0]        wr_unit, rd_unit;
    reg_sel_e             wr_sel, rd_sel;

    assign wr_unit = wr_addr[AW-1:1];
    assign rd_unit = rd_addr[AW-1:1];
    assign wr_sel  = reg_sel_e'(wr_addr[0]);
    assign rd_sel  = reg_sel_e'(rd_addr[0]);

    adc_trig_sync u_sync (
        .clk     (clk),
        .por_n   (por_n),
        .pin_n_i (ext_trig_n),
        .tmr_i   (tmr_trig),
        .trig_o  (trig)
    );

    for (genvar u = 0; u < NUNITS; u++) begin : g_unit
        logic hit;
        assign hit = wr_en && (wr_unit == UW'(u));

        adc_unit_seq #(
            .CH_PER_UNIT (CH_PER_UNIT),
            .NCH         (NCH),
            .UNIT_IDX    (u)
        ) u_seq (
            .clk       (clk),
            .por_n     (por_n),
            .man_rst_i (man_rst),
            .standby_i (standby),
            .trig_i    (trig),
            .wr_gate_i (hit && wr_sel == REG_GATE),
            .wr_cfg_i  (hit && wr_sel == REG_CFG),
            .wr_data_i (wr_data),
            .done_i    (conv_done[u]),
            .chan_o    (conv_chan[u*CH_W +: CH_W]),
            .strobe_o  (conv_start[u]),
            .gate_rd_o (gate_rd[u]),
            .cfg_rd_o  (cfg_rd[u])
        );
    end

    assign rd_data = (rd_sel == REG_CFG) ? cfg_rd[rd_unit] : gate_rd[rd_unit];
endmodule

// File: tb/adc_scan_ctrl_tb.sv
module adc_scan_ctrl_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, man_rst = 1'b0, standby = 1'b0;
    logic       ext_trig_n = 1'b1, tmr_trig = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] conv_done = '0, conv_start;
    logic [5:0] conv_chan;

    int    errs = 0, checks = 0, cyc = 0;
    string req = "R1";

    int m_en[2], m_scan[2], m_sel[2], m_busy[2], m_idx[2], m_stb[2];
    int s1 = 1, s2 = 1, pv = 1;

    always #2 clk = ~clk;

    adc_scan_ctrl u_dut (
        .clk(clk), .por_n(por_n), .man_rst(man_rst), .standby(standby),
        .ext_trig_n(ext_trig_n), .tmr_trig(tmr_trig),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan)
    );

    always @(posedge clk) begin
        cyc++;
        if (!por_n) begin
            for (int u = 0; u < 2; u++) begin
                m_en[u] = 0; m_scan[u] = 0; m_sel[u] = 0;
                m_busy[u] = 0; m_idx[u] = 0; m_stb[u] = 0;
            end
            s1 = 1; s2 = 1; pv = 1;
        end else begin
            int hw;
            hw = ((pv == 1 && s2 == 0) || tmr_trig) ? 1 : 0;
            pv = s2; s2 = s1; s1 = int'(ext_trig_n);
            for (int u = 0; u < 2; u++) begin
                int wg, wc, stb_old, idx_old, busy_old, scan_old, sel_old;
                wg = (wr_en && wr_addr == 2'(u*2)) ? 1 : 0;
                wc = (wr_en && wr_addr == 2'(u*2+1)) ? 1 : 0;
                stb_old = m_stb[u]; idx_old = m_idx[u]; busy_old = m_busy[u];
                scan_old = m_scan[u]; sel_old = m_sel[u];
                m_stb[u] = 0;
                if (standby) begin
                    m_en[u] = 0; m_scan[u] = 0; m_sel[u] = 0; m_busy[u] = 0; m_idx[u] = 0;
                end else if (man_rst) begin
                    m_busy[u] = 0; m_idx[u] = 0;
                end else begin
                    if (wg) m_en[u] = wr_data[7];
                    if (wc) begin m_scan[u] = wr_data[4]; m_sel[u] = wr_data[1:0]; end
                    if (busy_old) begin
                        if (wc && !wr_data[5]) begin m_busy[u] = 0; m_idx[u] = 0; end
                        else if (conv_done[u] && !stb_old) begin
                            if (scan_old) begin
                                m_idx[u] = (idx_old >= sel_old) ? 0 : idx_old + 1;
                                m_stb[u] = 1;
                            end else m_busy[u] = 0;
                        end
                    end else if ((wc && wr_data[5]) || (hw && m_en[u] == 1 && !wg) ||
                                 (hw && wg && busy_old == 0 && en_before(u, wg))) begin
                        m_busy[u] = 1; m_idx[u] = 0; m_stb[u] = 1;
                    end
                end
            end
        end
    end

    // the enable used by a trigger is the value held before the edge
    int en_prev[2];
    always @(negedge clk) for (int u = 0; u < 2; u++) en_prev[u] = m_en[u];
    function automatic int en_before(int u, int wg);
        return (wg != 0) ? en_prev[u] : 0;
    endfunction

    function automatic logic [7:0] model_rd(logic [1:0] a);
        int u;
        u = int'(a[1]);
        if (a[0]) return 8'((m_busy[u] << 5) | (m_scan[u] << 4) | m_sel[u]);
        return {m_en[u][0], 7'h7F};
    endfunction

    task automatic check(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", r, what, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(negedge clk);
        for (int u = 0; u < 2; u++) begin
            check(req, $sformatf("start[%0d]", u), int'(conv_start[u]), m_stb[u]);
            check(req, $sformatf("chan[%0d]", u), int'(conv_chan[u*3 +: 3]),
                  u*4 + (m_scan[u] != 0 ? m_idx[u] : m_sel[u]));
        end
        check(req, "rd_data", int'(rd_data), int'(model_rd(rd_addr)));
        rd_addr = rd_addr + 2'd1;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_expect(string r, logic [1:0] a, logic [7:0] e);
        rd_addr = a;
        #1;
        check(r, "read", int'(rd_data), int'(e));
    endtask

    task automatic done_pulse(int u);
        conv_done[u] = 1'b1; step(); conv_done[u] = 1'b0;
    endtask

    initial begin
        steps(3);
        por_n = 1'b1;
        step();
        req = "R1";
        rd_expect("R1", 2'd0, 8'h7F); rd_expect("R1", 2'd1, 8'h00);
        rd_expect("R1", 2'd2, 8'h7F); rd_expect("R1", 2'd3, 8'h00);
        check("R1", "chan1", int'(conv_chan[5:3]), 4);
        steps(2);

        req = "R2";
        wr(2'd0, 8'h00); rd_expect("R2", 2'd0, 8'h7F);
        wr(2'd0, 8'h80); rd_expect("R2", 2'd0, 8'hFF);
        wr(2'd2, 8'h55); rd_expect("R2", 2'd2, 8'h7F);
        wr(2'd0, 8'h00); step();

        req = "R3";
        for (int s = 0; s < 4; s++) begin
            wr(2'd3, 8'(s));
            check("R3", "single chan", int'(conv_chan[5:3]), 4 + s);
            req = "R13"; wr(2'd3, 8'(8'h20 | s)); steps(2);
            req = "R12"; done_pulse(1); step();
            rd_expect("R12", 2'd3, 8'(s));
            req = "R3";
        end

        req = "R4";
        wr(2'd1, 8'h32);
        for (int k = 0; k < 5; k++) begin steps(2); done_pulse(0); end
        req = "R8"; conv_done[0] = 1'b1; steps(3); conv_done[0] = 1'b0; step();
        req = "R12"; rd_expect("R12", 2'd1, 8'h32);
        wr(2'd1, 8'h12); step();
        rd_expect("R12", 2'd1, 8'h12);
        wr(2'd1, 8'h00); wr(2'd3, 8'h00);

        req = "R5";
        ext_trig_n = 1'b0; steps(3); ext_trig_n = 1'b1; steps(4);
        tmr_trig = 1'b1; step(); tmr_trig = 1'b0; steps(2);
        check("R5", "no start", int'(conv_start), 0);

        req = "R6";
        wr(2'd0, 8'h80);
        ext_trig_n = 1'b0; steps(2);
        check("R6", "not yet", int'(conv_start[0]), 0);
        step();
        check("R6", "pin start", int'(conv_start[0]), 1);
        check("R7", "unit1 idle", int'(conv_start[1]), 0);
        ext_trig_n = 1'b1;
        req = "R9"; steps(2); tmr_trig = 1'b1; step(); tmr_trig = 1'b0;
        ext_trig_n = 1'b0; steps(4); ext_trig_n = 1'b1; steps(3);
        req = "R6"; done_pulse(0); steps(2);

        req = "R7";
        wr(2'd2, 8'h80);
        tmr_trig = 1'b1; step(); tmr_trig = 1'b0;
        check("R7", "both start", int'(conv_start), 3);
        steps(2);
        req = "R9"; wr(2'd1, 8'h23); steps(2);

        req = "R10";
        wr(2'd1, 8'h13); wr(2'd1, 8'h33); steps(2);
        man_rst = 1'b1; step(); man_rst = 1'b0; step();
        rd_expect("R10", 2'd0, 8'hFF); rd_expect("R10", 2'd1, 8'h13);
        steps(2);

        req = "R11";
        standby = 1'b1; step(); standby = 1'b0; step();
        rd_expect("R11", 2'd0, 8'h7F); rd_expect("R11", 2'd1, 8'h00);
        rd_expect("R11", 2'd2, 8'h7F);
        steps(3);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #400000;
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule